// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block recovers asynchronous serial words from one input line. A free-running baud tick from outside sets the time base. A falling edge on the synchronized line arms the receiver. Each bit is then sampled three times around its centre, and the bit takes the value that at least two of the three samples agree on. If the start bit votes high, the edge is treated as noise and the receiver goes back to waiting. After the data bits, the stop bit is voted. A high stop stores the word. A low stop throws the word away without raising any flag.

Each word holds 8 data bits, or 9 when nine-bit mode is selected. Data arrive least significant bit first. Stored words wait in a two-entry FIFO until the consumer pops them. A word that completes while the FIFO is full, and is not matched by a pop in the same cycle, is lost and latches an overrun flag. A speed select picks one of two tick-per-bit ratios, and each ratio has its own sample positions. With continuous mode off, the receiver accepts one word and then stays idle until its enable is toggled.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, `valid_o` and `overrun_o` are 0.
- R2: A bit is decided by majority over three samples taken on baud ticks. In high-speed mode (`hi_speed_i`=1) a bit lasts 16 ticks, with samples at tick offsets 7, 8 and 9 counted from 0. A single disagreeing sample does not change the bit. Two disagreeing samples do.
- R3: If the start bit votes high, the receiver returns to waiting for a falling edge and stores nothing. The next proper word is then received correctly.
- R4: In 8-bit mode (`nine_bit_i`=0), data bit k (k=0 first on the line) appears on `rd_data_o[k]`, and `rd_bit9_o` reads 0.
- R5: In 9-bit mode, nine data bits are received. The ninth bit appears on `rd_bit9_o` with its word.
- R6: A word whose stop bit votes low is discarded. It sets neither `valid_o` nor `overrun_o`, and the following word is received normally.
- R7: With `cont_en_i`=1 the receiver rearms after each word. With `cont_en_i`=0 it ignores the line after one word until `rx_en_i` goes low and then high again.
- R8: The FIFO holds 2 words in arrival order. `valid_o` is 1 while it is non-empty, and a one-cycle `rd_i` pops the head.
- R9: A good word that arrives while the FIFO is full, with no pop in that cycle, is dropped and sets `overrun_o`. `overrun_o` is cleared while `rx_en_i` is 0.
- R10: A good word that completes in the same cycle as a pop of a full FIFO is stored, and no overrun is raised.
- R11: While `rx_en_i` is 0, nothing is received.
- R12: In low-speed mode (`hi_speed_i`=0) a bit lasts 64 ticks, with samples at offsets 28, 32 and 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | One-cycle oversampling tick |
| rx_en_i | input | 1 | Receive enable; low also clears overrun |
| cont_en_i | input | 1 | Rearm after each word |
| nine_bit_i | input | 1 | Select 9 data bits |
| hi_speed_i | input | 1 | 16 ticks per bit when 1, 64 when 0 |
| rd_i | input | 1 | Pop the FIFO head |
| rd_data_o | output | 8 | FIFO head, low 8 bits |
| rd_bit9_o | output | 1 | FIFO head, ninth bit |
| valid_o | output | 1 | FIFO non-empty |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Two things can land on the same clock edge: the stop-bit vote that pushes a finished word, and a consumer pop of a full FIFO. The bench fills both entries and then starts a third word. It aligns a one-cycle `rd_i` with the baud tick that carries the stop bit's third sample, counting ticks from the start edge. It then judges the result at the ports: `overrun_o` must stay 0, and the FIFO must hold the second and third words in that order.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic       b8;
    logic [7:0] data;
  } rx_word_t;
endpackage

// File: rtl/uart_mv_sync.sv
module uart_mv_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_mv_sampler.sv
module uart_mv_sampler #(
  parameter int HI_TOTAL = 16,
  parameter int HI_S1    = 7,
  parameter int HI_S2    = 8,
  parameter int HI_S3    = 9,
  parameter int LO_TOTAL = 64,
  parameter int LO_S1    = 28,
  parameter int LO_S2    = 32,
  parameter int LO_S3    = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic hi_i,
  input  logic rxd_i,
  output logic bit_done_o,
  output logic bit_val_o
);
  localparam int MAXT = (HI_TOTAL > LO_TOTAL) ? HI_TOTAL : LO_TOTAL;
  localparam int CW   = $clog2(MAXT);
  localparam logic [CW-1:0] HI_LAST = CW'(HI_TOTAL - 1);
  localparam logic [CW-1:0] LO_LAST = CW'(LO_TOTAL - 1);
  localparam logic [CW-1:0] HI_P1 = CW'(HI_S1);
  localparam logic [CW-1:0] HI_P2 = CW'(HI_S2);
  localparam logic [CW-1:0] HI_P3 = CW'(HI_S3);
  localparam logic [CW-1:0] LO_P1 = CW'(LO_S1);
  localparam logic [CW-1:0] LO_P2 = CW'(LO_S2);
  localparam logic [CW-1:0] LO_P3 = CW'(LO_S3);

  logic [CW-1:0] cnt_q, last, p1, p2, p3;
  logic          s1_q, s2_q;

  always_comb begin
    last = hi_i ? HI_LAST : LO_LAST;
    p1   = hi_i ? HI_P1   : LO_P1;
    p2   = hi_i ? HI_P2   : LO_P2;
    p3   = hi_i ? HI_P3   : LO_P3;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
    end else if (run_i && tick_i) begin
      if (cnt_q == p1) s1_q <= rxd_i;
      if (cnt_q == p2) s2_q <= rxd_i;
      cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
    end
  end

  // third sample decides together with the two stored ones
  assign bit_done_o = run_i && tick_i && (cnt_q == p3);
  assign bit_val_o  = (s1_q & s2_q) | (s1_q & rxd_i) | (s2_q & rxd_i);
endmodule

// File: rtl/uart_mv_fifo.sv
module uart_mv_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [NW-1:0] FULL = NW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [NW-1:0]    cnt_q;
  logic             wr, rd;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign rd      = pop_i && !empty_o;
  assign wr      = push_i && (!full_o || rd);
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (rd) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({wr, rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          mem_q[i] <= '0;
        else if (wr && wp_q == AW'(i))        mem_q[i] <= wdata_i;
      end
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o); // R9
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
  import uart_mv_pkg::*;
#(
  parameter int HI_TOTAL   = 16,
  parameter int HI_S1      = 7,
  parameter int HI_S2      = 8,
  parameter int HI_S3      = 9,
  parameter int LO_TOTAL   = 64,
  parameter int LO_S1      = 28,
  parameter int LO_S2      = 32,
  parameter int LO_S3      = 36,
  parameter int FIFO_DEPTH = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       baud_tick_i,
  input  logic       rx_en_i,
  input  logic       cont_en_i,
  input  logic       nine_bit_i,
  input  logic       hi_speed_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       rd_bit9_o,
  output logic       valid_o,
  output logic       overrun_o
);
  localparam int WW = $bits(rx_word_t);
  localparam int BW = $clog2(WW + 1);

  rx_state_e     state_q;
  logic          rxs, rx_prev_q, fall;
  logic          en_q, en_rise;
  logic [8:0]    rsr_q;
  logic [BW-1:0] left_q;
  logic          bit_done, bit_val;
  logic          push, full, empty;
  logic          ovr_q;
  rx_word_t      wword, rword;

  uart_mv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rxs)
  );

  uart_mv_sampler #(
    .HI_TOTAL(HI_TOTAL), .HI_S1(HI_S1), .HI_S2(HI_S2), .HI_S3(HI_S3),
    .LO_TOTAL(LO_TOTAL), .LO_S1(LO_S1), .LO_S2(LO_S2), .LO_S3(LO_S3)
  ) u_samp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (state_q == ST_IDLE),
    .run_i     (state_q == ST_START || state_q == ST_DATA || state_q == ST_STOP),
    .tick_i    (baud_tick_i),
    .hi_i      (hi_speed_i),
    .rxd_i     (rxs),
    .bit_done_o(bit_done),
    .bit_val_o (bit_val)
  );

  assign fall    = rx_prev_q && !rxs;
  assign en_rise = rx_en_i && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_prev_q <= 1'b1;
      en_q      <= 1'b0;
    end else begin
      rx_prev_q <= rxs;
      en_q      <= rx_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rsr_q   <= '0;
      left_q  <= '0;
    end else if (!rx_en_i) begin
      state_q <= ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  if (en_rise) state_q <= ST_IDLE;
        ST_IDLE: if (fall) state_q <= ST_START;
        ST_START: if (bit_done) begin
          if (bit_val) state_q <= ST_IDLE;  // noise, not a start bit
          else begin
            state_q <= ST_DATA;
            left_q  <= nine_bit_i ? BW'(9) : BW'(8);
          end
        end
        ST_DATA: if (bit_done) begin
          rsr_q  <= {bit_val, rsr_q[8:1]};
          left_q <= left_q - 1'b1;
          if (left_q == BW'(1)) state_q <= ST_STOP;
        end
        ST_STOP: if (bit_done) state_q <= cont_en_i ? ST_IDLE : ST_OFF;
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign push = (state_q == ST_STOP) && bit_done && bit_val && rx_en_i;

  // 8-bit words sit one place high in the shifter
  always_comb begin
    if (nine_bit_i) wword = rx_word_t'(rsr_q);
    else            wword = rx_word_t'({1'b0, rsr_q[8:1]});
  end

  uart_mv_fifo #(.WIDTH(WW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(wword),
    .pop_i  (rd_i),
    .rdata_o(rword),
    .full_o (full),
    .empty_o(empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovr_q <= 1'b0;
    else if (!rx_en_i)               ovr_q <= 1'b0;
    else if (push && full && !rd_i)  ovr_q <= 1'b1;
  end

  assign rd_data_o = rword.data;
  assign rd_bit9_o = rword.b8;
  assign valid_o   = !empty;
  assign overrun_o = ovr_q;

  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !overrun_o); // R9
  AST_VALID_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(state_q) == ST_STOP); // R6
  AST_OFF_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |=> (state_q == ST_OFF || state_q == ST_IDLE)); // R7
  AST_DATA_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) != ST_DATA) |-> $past(state_q) == ST_START); // R3
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> state_q == ST_OFF); // R11
endmodule

// File: tb/uart_mv_rx_bench.sv
`timescale 1ns/1ps
module uart_mv_rx_bench;
  logic clk_i = 0, rst_ni = 0;
  logic rx_i = 1, rx_en_i = 0, cont_en_i = 1, nine_bit_i = 0, hi_speed_i = 1, rd_i = 0;
  logic [7:0] rd_data_o;
  logic rd_bit9_o, valid_o, overrun_o;
  logic [1:0] div = 0;
  logic tick;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;
  always @(negedge clk_i) div <= div + 1'b1;
  assign tick = (div == 2'd3);

  uart_mv_rx u_uart_mv_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .baud_tick_i(tick),
    .rx_en_i(rx_en_i), .cont_en_i(cont_en_i), .nine_bit_i(nine_bit_i),
    .hi_speed_i(hi_speed_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .rd_bit9_o(rd_bit9_o), .valid_o(valid_o), .overrun_o(overrun_o)
  );

  function automatic int tpb();
    return hi_speed_i ? 16 : 64;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk_i); while (!tick);
    #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  // one bit; optional inversion of ticks [gf, gf+gl)
  task automatic send_bit(input logic b, input int gf, input int gl);
    rx_i = b;
    if (gl > 0) begin
      wait_ticks(gf);
      rx_i = ~b;
      wait_ticks(gl);
      rx_i = b;
      wait_ticks(tpb() - gf - gl);
    end else wait_ticks(tpb());
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input logic stop_v,
                            input int gbit, input int gf, input int gl);
    wait_tick();
    send_bit(1'b0, 0, 0);
    for (int i = 0; i < nb; i++) send_bit(d[i], gf, (i == gbit) ? gl : 0);
    send_bit(stop_v, 0, 0);
    send_bit(1'b1, 0, 0);
  endtask

  task automatic pop();
    @(negedge clk_i); rd_i = 1;
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic expect_word(input string req, input int d, input int b9);
    @(negedge clk_i);
    chk({req, " valid"}, valid_o, 1);
    chk({req, " data"}, rd_data_o, d);
    chk({req, " bit9"}, rd_bit9_o, b9);
    pop();
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk_i);
    chk({req, " empty"}, valid_o, 0);
  endtask

  task automatic toggle_en();
    @(negedge clk_i); rx_en_i = 0;
    repeat (3) @(negedge clk_i);
    rx_en_i = 1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 valid", valid_o, 0);
    chk("R1 overrun", overrun_o, 0);
  endtask

  task automatic t_basic();
    send_frame(9'h0A5, 8, 1, -1, 0, 0);
    expect_word("R4 8-bit A5", 8'hA5, 0);
    expect_empty("R8 after pop");
  endtask

  task automatic t_lowspeed();
    hi_speed_i = 0;
    send_frame(9'h03C, 8, 1, -1, 0, 0);
    expect_word("R12 low speed 3C", 8'h3C, 0);
    hi_speed_i = 1;
  endtask

  task automatic t_nine();
    nine_bit_i = 1;
    send_frame(9'h1C3, 9, 1, -1, 0, 0);
    expect_word("R5 9-bit 1C3", 8'hC3, 1);
    send_frame(9'h03C, 9, 1, -1, 0, 0);
    expect_word("R5 9-bit 03C", 8'h3C, 0);
    nine_bit_i = 0;
  endtask

  task automatic t_majority();
    send_frame(9'h000, 8, 1, 0, 8, 1);   // one sample of bit 0 flipped
    expect_word("R2 single glitch", 8'h00, 0);
    send_frame(9'h000, 8, 1, 0, 7, 2);   // two samples of bit 0 flipped
    expect_word("R2 double glitch", 8'h01, 0);
  endtask

  task automatic t_false_start();
    wait_tick();
    rx_i = 0; wait_ticks(4);
    rx_i = 1; wait_ticks(40);
    expect_empty("R3 false start");
    send_frame(9'h05A, 8, 1, -1, 0, 0);
    expect_word("R3 after false start", 8'h5A, 0);
  endtask

  task automatic t_bad_stop();
    send_frame(9'h077, 8, 0, -1, 0, 0);
    expect_empty("R6 bad stop");
    chk("R6 no overrun", overrun_o, 0);
    send_frame(9'h066, 8, 1, -1, 0, 0);
    expect_word("R6 next word", 8'h66, 0);
  endtask

  task automatic t_single_shot();
    cont_en_i = 0;
    send_frame(9'h012, 8, 1, -1, 0, 0);
    send_frame(9'h034, 8, 1, -1, 0, 0);
    expect_word("R7 first kept", 8'h12, 0);
    expect_empty("R7 second ignored");
    toggle_en();
    send_frame(9'h056, 8, 1, -1, 0, 0);
    expect_word("R7 after toggle", 8'h56, 0);
    cont_en_i = 1;
    toggle_en();
  endtask

  task automatic t_disabled();
    @(negedge clk_i); rx_en_i = 0;
    send_frame(9'h0F0, 8, 1, -1, 0, 0);
    expect_empty("R11 disabled");
    rx_en_i = 1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_overrun();
    send_frame(9'h001, 8, 1, -1, 0, 0);
    send_frame(9'h002, 8, 1, -1, 0, 0);
    send_frame(9'h003, 8, 1, -1, 0, 0);
    @(negedge clk_i);
    chk("R9 overrun set", overrun_o, 1);
    expect_word("R8 order first", 8'h01, 0);
    expect_word("R8 order second", 8'h02, 0);
    expect_empty("R9 third dropped");
    chk("R9 sticky", overrun_o, 1);
    toggle_en();
    chk("R9 cleared", overrun_o, 0);
  endtask

  task automatic t_coincide();
    send_frame(9'h011, 8, 1, -1, 0, 0);
    send_frame(9'h022, 8, 1, -1, 0, 0);
    fork
      send_frame(9'h033, 8, 1, -1, 0, 0);
      begin
        wait_tick();
        wait_ticks(9 * 16 + 9);            // up to the tick before the stop vote
        repeat (3) @(posedge clk_i);
        #1 rd_i = 1;
        @(posedge clk_i);
        #1 rd_i = 0;
      end
    join
    @(negedge clk_i);
    chk("R10 no overrun", overrun_o, 0);
    expect_word("R10 head", 8'h22, 0);
    expect_word("R10 new word", 8'h33, 0);
    expect_empty("R10 drained");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    rx_en_i = 1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_basic();
    t_lowspeed();
    t_nine();
    t_majority();
    t_false_start();
    t_bad_stop();
    t_single_shot();
    t_disabled();
    t_overrun();
    t_coincide();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule